// File: doc/BRIEF.md
# Ramp Current Trim Calibration Sequencer

This block searches for the current-source trim code of a ramp-type ADC so that the ramp peak lands as close as possible to the nominal full-scale level. Software supplies the ADC maximum count and pulses a start input. The block then works out a target code equal to five sevenths of that count, clears the trim code, and steers the ADC multiplexer to the internal reference channel.

It asks the ADC for one conversion at a time over a request/valid handshake. If the returned code is above the target, the trim code goes up by one and a new conversion is requested. A larger trim code means a larger ramp current, so the converted reference value falls towards the target. The search ends when a result is at or below the target. It also ends, with an error, if the trim code is already all ones and the result is still above the target.

A one-cycle done pulse marks the end of every search. Two sticky flags, success and error, report the outcome until the next start.

Top module: `ramp_trim_cal`

## Requirements
- R1: After a synchronous active-low reset, the trim code is 0 and busy, done, conv_req, cal_ok and cal_err are all low. mux_sel is 0.
- R2: The target code is (max_count × 5) / 7 in integer arithmetic, with the fraction dropped. It is captured at start. For example, 1023 gives 730 and 1000 gives 714.
- R3: When start is seen high while idle, the block does the following at the next edge: it clears the trim code, clears both sticky flags, raises busy and drives mux_sel to the reference-channel code CAL_CH (7 by default). mux_sel holds that code for as long as busy is high.
- R4: A conversion result strictly greater than the target, with the trim code below all ones, raises the trim code by exactly one. The block then issues a new request.
- R5: A result less than or equal to the target ends the search. The trim code is held and cal_ok is set.
- R6: A result above the target while the trim code is all ones (63 by default) ends the search. The trim code stays at all ones and cal_err is set.
- R7: conv_req is high for exactly one cycle. That cycle is the second cycle after start is taken, or the cycle after a trim increment. Only a conv_valid that arrives after that request cycle is used. A conv_valid in the request cycle itself, or while idle, has no effect.
- R8: done is a single-cycle pulse in the cycle busy falls. cal_ok and cal_err keep their value until the next accepted start. They are never both high.
- R9: start is ignored while busy is high. Neither the target nor the trim code changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a calibration when idle |
| max_count | input | CW (10) | ADC maximum count |
| conv_req | output | 1 | One-cycle conversion request |
| conv_valid | input | 1 | Conversion result valid |
| conv_data | input | CW (10) | Conversion result |
| mux_sel | output | SW (3) | ADC multiplexer channel select |
| trim | output | TW (6) | Current-source trim code |
| busy | output | 1 | Calibration in progress |
| done | output | 1 | One-cycle end-of-calibration pulse |
| cal_ok | output | 1 | Sticky: search ended at or below target |
| cal_err | output | 1 | Sticky: trim code ran out with result above target |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a conv_valid pulse and the request cycle: the bench drives a stale zero result exactly while conv_req is high. A zero would end the search at once if it were used, so a run that continues to the right trim code shows the stale result was dropped. The second pair is start and the end of a search: the bench holds start high across the final comparison. The cycle-by-cycle model requires that start is ignored in the done cycle and accepted on the very next idle cycle. It also requires that the sticky flag clears at that restart.

// File: rtl/cal_pkg.sv
// Shared types for the ramp trim calibration sequencer.
// Assumes: used by every module of the block, compiled first.
package cal_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_REQ   = 2'd2,
        ST_WAIT  = 2'd3
    } cal_state_e;
endpackage

// File: rtl/cal_target.sv
// Computes and holds the comparison target, floor(max_count * 5 / 7).
// Assumes: load is a single-cycle strobe issued when a calibration starts;
// the divisor is a constant so the quotient maps to fixed logic.
module cal_target #(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] max_count,
    output logic [CW-1:0] target
);
    localparam int PW = CW + 3;

    logic [PW-1:0] prod;
    logic [PW-1:0] quot;

    // Scale by five with three guard bits, then divide by seven (truncating).
    always_comb begin
        prod = {3'b000, max_count} * PW'(5);
        quot = prod / PW'(7);
    end

    // Capture the target at start; hold it for the whole search.
    always_ff @(posedge clk) begin
        if (!rst_n)    target <= '0;
        else if (load) target <= quot[CW-1:0];
    end

    // R2
    target_le_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (target <= $past(max_count)));
endmodule

// File: rtl/cal_trim_ctr.sv
// Trim code register: clears on request, steps up by one, flags all-ones.
// Assumes: the controller never asks for a step while the code is all ones.
module cal_trim_ctr #(
    parameter int TW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [TW-1:0] trim,
    output logic          at_max
);
    // Clear on reset or start, otherwise advance by one on request.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) trim <= '0;
        else if (inc)      trim <= trim + 1'b1;
    end

    // All-ones detect for the saturation stop.
    assign at_max = &trim;

    // R4
    trim_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trim != $past(trim)) |-> ((trim == $past(trim) + 1'b1) || (trim == '0)));

    // R6
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(inc && at_max && !clr));
endmodule

// File: rtl/ramp_trim_cal.sv
// Linear-search sequencer for the ramp ADC current trim.
// Computes the target, clears the trim, selects the reference channel, then
// requests conversions and raises the trim until a result is at or below target.
// Assumes: the ADC answers each conv_req with one conv_valid some cycles later.
module ramp_trim_cal
    import cal_pkg::*;
#(
    parameter int CW     = 10,
    parameter int TW     = 6,
    parameter int SW     = 3,
    parameter int CAL_CH = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] max_count,
    output logic          conv_req,
    input  logic          conv_valid,
    input  logic [CW-1:0] conv_data,
    output logic [SW-1:0] mux_sel,
    output logic [TW-1:0] trim,
    output logic          busy,
    output logic          done,
    output logic          cal_ok,
    output logic          cal_err
);
    localparam logic [SW-1:0] REF_SEL = SW'(CAL_CH);

    cal_state_e    state;
    logic [CW-1:0] target;
    logic          take_start;
    logic          result_in;
    logic          above;
    logic          at_max;
    logic          step_up;

    // Decode the current cycle's events for the datapath.
    always_comb begin
        take_start = (state == ST_IDLE) && start;
        result_in  = (state == ST_WAIT) && conv_valid;
        above      = conv_data > target;
        step_up    = result_in && above && !at_max;
    end

    cal_target #(.CW(CW)) u_target (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (take_start),
        .max_count (max_count),
        .target    (target)
    );

    cal_trim_ctr #(.TW(TW)) u_trim (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (take_start),
        .inc    (step_up),
        .trim   (trim),
        .at_max (at_max)
    );

    // Sequence state and the registered status outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            busy    <= 1'b0;
            done    <= 1'b0;
            cal_ok  <= 1'b0;
            cal_err <= 1'b0;
            mux_sel <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: if (start) begin
                    state   <= ST_SETUP;
                    busy    <= 1'b1;
                    cal_ok  <= 1'b0;
                    cal_err <= 1'b0;
                    mux_sel <= REF_SEL;
                end
                ST_SETUP: state <= ST_REQ;
                ST_REQ:   state <= ST_WAIT;
                ST_WAIT: if (conv_valid) begin
                    if (step_up) begin
                        state <= ST_REQ;
                    end else begin
                        state   <= ST_IDLE;
                        busy    <= 1'b0;
                        done    <= 1'b1;
                        mux_sel <= '0;
                        cal_ok  <= !above;
                        cal_err <= above;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // One request per trim value, issued from the request state only.
    assign conv_req = (state == ST_REQ);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R8
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cal_ok, cal_err}));
    // R3
    mux_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (mux_sel == REF_SEL));
    // R7
    req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |=> !conv_req);
    // R6
    err_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_err |-> at_max);
endmodule

// File: tb/ramp_trim_cal_tb.sv
`timescale 1ns/1ps
module ramp_trim_cal_tb;
    localparam int CW = 10, TW = 6, SW = 3, CAL_CH = 7;
    localparam int TMAX = 63;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [CW-1:0] max_count = '0;
    logic          conv_req;
    logic          conv_valid = 1'b0;
    logic [CW-1:0] conv_data = '0;
    logic [SW-1:0] mux_sel;
    logic [TW-1:0] trim;
    logic          busy, done, cal_ok, cal_err;

    always #2.5 clk = ~clk;

    ramp_trim_cal #(.CW(CW), .TW(TW), .SW(SW), .CAL_CH(CAL_CH)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .max_count(max_count),
        .conv_req(conv_req), .conv_valid(conv_valid), .conv_data(conv_data),
        .mux_sel(mux_sel), .trim(trim), .busy(busy), .done(done),
        .cal_ok(cal_ok), .cal_err(cal_err)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
        end
    endtask

    // Behavioural reference: phase 0 idle, 1 setup, 2 request, 3 waiting.
    int m_ph = 0, m_tgt = 0, m_trim = 0;
    bit m_busy = 0, m_done = 0, m_ok = 0, m_err = 0;
    int m_mux = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_tgt = 0; m_trim = 0; m_busy = 0; m_done = 0;
            m_ok = 0; m_err = 0; m_mux = 0;
        end else begin
            m_done = 0;
            if (m_ph == 0) begin
                if (start) begin
                    m_ph = 1; m_tgt = (int'(max_count) * 5) / 7; m_trim = 0;
                    m_busy = 1; m_ok = 0; m_err = 0; m_mux = CAL_CH;
                end
            end else if (m_ph == 1) m_ph = 2;
            else if (m_ph == 2) m_ph = 3;
            else if (conv_valid) begin
                if (int'(conv_data) > m_tgt && m_trim < TMAX) begin
                    m_trim++; m_ph = 2;
                end else begin
                    m_ph = 0; m_busy = 0; m_done = 1; m_mux = 0;
                    m_ok = !(int'(conv_data) > m_tgt);
                    m_err = int'(conv_data) > m_tgt;
                end
            end
        end
    end

    // ADC stand-in: result falls linearly with trim code.
    int adc_base = 0, adc_step = 1, adc_lat = 1, cd = 0;
    bit stale_en = 0;
    always @(negedge clk) begin
        // Compare every output against the model (R1 R3 R4 R5 R6 R7 R8).
        chk(int'(trim) == m_trim, "R4 trim", int'(trim), m_trim);
        chk(busy == m_busy, "R3 busy", int'(busy), int'(m_busy));
        chk(done == m_done, "R8 done", int'(done), int'(m_done));
        chk(cal_ok == m_ok, "R5 cal_ok", int'(cal_ok), int'(m_ok));
        chk(cal_err == m_err, "R6 cal_err", int'(cal_err), int'(m_err));
        chk(int'(mux_sel) == m_mux, "R3 mux_sel", int'(mux_sel), m_mux);
        chk(conv_req == (m_ph == 2), "R7 conv_req", int'(conv_req), int'(m_ph == 2));
        conv_valid <= 1'b0;
        if (!rst_n) cd = 0;
        else if (cd > 0) begin
            cd--;
            if (cd == 0) begin
                int d;
                d = adc_base - int'(trim) * adc_step;
                if (d < 0) d = 0;
                if (d > 1023) d = 1023;
                conv_valid <= 1'b1;
                conv_data  <= CW'(d);
            end
        end
        if (rst_n && conv_req) begin
            cd = adc_lat;
            if (stale_en) begin
                conv_valid <= 1'b1;
                conv_data  <= '0;
            end
        end
    end

    task automatic pulse_start(input int mc);
        @(negedge clk);
        max_count = CW'(mc); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        do @(negedge clk); while (!m_done);
        @(negedge clk);
    endtask

    task automatic run(input int mc, input int base, input int step, input int lat,
                       input bit stale, input int exp_trim, input bit exp_err, input string tag);
        adc_base = base; adc_step = step; adc_lat = lat; stale_en = stale;
        pulse_start(mc);
        wait_done();
        chk(int'(trim) == exp_trim, tag, int'(trim), exp_trim);
        chk(cal_err == exp_err && cal_ok == !exp_err, {tag, " flags"}, int'(cal_err), int'(exp_err));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(trim == 0 && !busy && !done && !conv_req && !cal_ok && !cal_err && mux_sel == 0,
            "R1 reset", int'(trim), 0);
        rst_n = 1'b1;
        // R4 R5: 900-20t <= 714 first at t=10
        run(1000, 900, 20, 1, 0, 10, 0, "R4 linear search");
        // R5 equality ends: target 500, 560-20*3 = 500
        run(700, 560, 20, 3, 0, 3, 0, "R5 equal ends");
        // R5 immediate stop at zero trim
        run(700, 400, 5, 2, 0, 0, 0, "R5 first below");
        // R2 truncation: 1023 -> 730, 733-3 = 730 ends at 3
        run(1023, 733, 1, 1, 0, 3, 0, "R2 truncated target");
        // R6 saturation
        run(700, 1000, 1, 1, 0, TMAX, 1, "R6 saturate");
        // R7 stale zero in request cycle must be ignored
        run(1000, 900, 20, 2, 1, 10, 0, "R7 stale ignored");
        // R9 start while busy ignored
        adc_base = 900; adc_step = 20; adc_lat = 2; stale_en = 0;
        pulse_start(1000);
        repeat (6) @(negedge clk);
        max_count = 10'd100; start = 1'b1;
        @(negedge clk); start = 1'b0;
        wait_done();
        chk(int'(trim) == 10, "R9 start ignored while busy", int'(trim), 10);
        // R8 sticky flags persist while idle
        repeat (5) @(negedge clk);
        chk(cal_ok && !cal_err && !done, "R8 sticky ok", int'(cal_ok), 1);
        // R8 start held across completion: restart right after done
        adc_base = 720; adc_step = 10; adc_lat = 1;
        @(negedge clk); max_count = 10'd1000; start = 1'b1;
        do @(negedge clk); while (!m_done);
        @(negedge clk);
        chk(busy && !cal_ok, "R8 restart clears sticky", int'(busy), 1);
        start = 1'b0;
        wait_done();
        chk(int'(trim) == 1, "R3 restart trim", int'(trim), 1);
        // R1 reset during a run
        adc_base = 1000; adc_step = 1;
        pulse_start(700);
        repeat (8) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(trim == 0 && !busy && !conv_req, "R1 mid-run reset", int'(trim), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(5ns * 100000);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule